// File: doc/BRIEF.md
# Exception Priority Sequencer

This block chooses the exception that a small processor core takes at two points: at the boundary just before an instruction starts, and at the end of an instruction's execution. At a boundary it checks the interrupt sources first and then the trace flag. At the end of an instruction it looks at the per-instruction trap strobes, and at the interrupt sources if the instruction can be interrupted. When nothing fires there, it reports that the instruction finished so the program counter can move on.

The decision is registered and comes out as a single-cycle result on the clock edge after the strobe. The result is an exception code, a vector number, a flag that picks which return address is saved, and, for interrupts, a request for an acknowledge bus cycle together with its address.

The non-maskable interrupt pin is asynchronous and active low. It is synchronised, and a falling edge on it sets a pending bit. That bit stays set until the core reports that the acknowledge cycle is done.

Top module: `exc_sequencer`

## Requirements
- R1: The non-maskable interrupt becomes pending only on a high-to-low transition of `nmiPinN`. Holding the pin low after the request has been acknowledged raises no new request.
- R2: A non-maskable interrupt that is taken reports code 1 and vector 1, whatever `busVector` holds. It also raises `iackReq` with `iackAddr` = 0xFFFF00.
- R3: At a boundary (`bndryStb`) the sources rank as follows: the pending non-maskable interrupt first, then a maskable request (`intReq` and `intEn`), then trace. A maskable interrupt reports code 2, takes its vector from `busVector`, and raises `iackReq` with `iackAddr` = 0xFFFE00. With `intEn` = 0 the maskable request is ignored.
- R4: Trace (code 9, vector 9) is taken only at a boundary with no interrupt pending and `traceFlag` = 1. It sets `retNext` = 1, meaning the saved return address is the next instruction.
- R5: At the end of an instruction (`endStb`), a qualified trap on `trapStb` is taken ahead of any interrupt. The strobe bits map to codes and vectors as follows: bit0 slave=3, bit1 illegal=4, bit2 supervisor call=5, bit3 divide by zero=6, bit4 flag=7, bit5 breakpoint=8, bit6 undefined=10. Every trap other than trace reports `retNext` = 0.
- R6: Strobe bit1 raises the illegal trap only when `userMode` = 1. Strobe bit4 raises the flag trap only when `flagBit` = 1. Otherwise these bits are ignored.
- R7: At the end of an instruction with no qualified trap, a pending interrupt is taken only when `interruptible` = 1.
- R8: At the end of an instruction with no trap and no interrupt taken, `instrDone` pulses for one cycle and `excValid` stays 0.
- R9: Every result appears on the clock edge after the strobe and lasts one cycle. While `excValid` = 0, `excCode`, `vecNum`, `retNext`, `iackReq` and `iackAddr` are all 0.
- R10: The non-maskable pending bit stays set until `iackDone`. A second falling edge that arrives while the bit is set merges into it, so one acknowledge clears both.
- R11: After reset, all outputs are 0 and no non-maskable interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiPinN | input | 1 | Asynchronous non-maskable interrupt pin, falling edge active |
| iackDone | input | 1 | Core finished the acknowledge cycle; clears the non-maskable pending bit |
| intReq | input | 1 | Maskable interrupt request level |
| intEn | input | 1 | Maskable interrupt enable |
| traceFlag | input | 1 | Trace pending flag |
| bndryStb | input | 1 | Instruction boundary strobe |
| endStb | input | 1 | End-of-execution strobe |
| interruptible | input | 1 | Current instruction may be interrupted |
| trapStb | input | 7 | Trap condition strobes (see R5) |
| userMode | input | 1 | Processor in user mode |
| flagBit | input | 1 | Status flag bit |
| busVector | input | VEC_W | Vector value returned on the bus for maskable interrupts |
| excValid | output | 1 | An exception was selected this cycle |
| excCode | output | 4 | Selected exception code |
| vecNum | output | VEC_W | Vector number |
| retNext | output | 1 | 1: save the next instruction address; 0: save the current one |
| iackReq | output | 1 | Request an interrupt-acknowledge bus cycle |
| iackAddr | output | ADDR_W | Address of the acknowledge cycle |
| instrDone | output | 1 | Instruction completed without exception |

## Verification
The bench builds the block with its default parameters: an 8-bit vector, a 24-bit address and a two-stage synchroniser. With these values the reference model's pin history is three samples deep, so the exact cycle at which a pin edge becomes a pending request is compared on every clock. The fixed acknowledge addresses and the vector passthrough from `busVector` are then visible at the ports, so it can be confirmed that the non-maskable vector ignores the bus.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    EXC_NONE  = 4'd0,
    EXC_NMI   = 4'd1,
    EXC_INT   = 4'd2,
    EXC_SLAVE = 4'd3,
    EXC_ILL   = 4'd4,
    EXC_SVC   = 4'd5,
    EXC_DVZ   = 4'd6,
    EXC_FLG   = 4'd7,
    EXC_BPT   = 4'd8,
    EXC_TRC   = 4'd9,
    EXC_UND   = 4'd10
  } excCode_e;

  localparam int NUM_TRAPS = 7;
  localparam int TRAP_ILL_BIT = 1;
  localparam int TRAP_FLG_BIT = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;      // register an exception
    logic     done;      // instruction completed cleanly
    logic     ackCycle;  // acknowledge bus cycle wanted
    logic     nmiSel;    // acknowledge belongs to the non-maskable source
    excCode_e code;
  } selStb_t;

  function automatic excCode_e trapCodeOf(input int idx);
    case (idx)
      0:       return EXC_SLAVE;
      1:       return EXC_ILL;
      2:       return EXC_SVC;
      3:       return EXC_DVZ;
      4:       return EXC_FLG;
      5:       return EXC_BPT;
      default: return EXC_UND;
    endcase
  endfunction

endpackage

// File: rtl/exc_nmi_edge.sv
module exc_nmi_edge #(
  parameter int SYNC_STAGES = 2   // must be at least 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  input  logic ackDone,
  output logic pending
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic fallSeen;

  assign fallSeen = prevQ & ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      prevQ   <= 1'b1;
      pending <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinN};
      prevQ   <= syncQ[SYNC_STAGES-1];
      pending <= fallSeen | (pending & ~ackDone);
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic                 bndryStb,
  input  logic                 endStb,
  input  logic                 interruptible,
  input  logic                 nmiPend,
  input  logic                 intReq,
  input  logic                 intEn,
  input  logic                 traceFlag,
  input  logic [NUM_TRAPS-1:0] trapStb,
  input  logic                 userMode,
  input  logic                 flagBit,
  output selStb_t              sel
);
  logic [NUM_TRAPS-1:0] qualTrap;
  logic                 anyTrap;
  logic                 anyInt;
  excCode_e             trapCode;

  // qualify the strobes that depend on status bits
  always_comb begin
    qualTrap = trapStb;
    qualTrap[TRAP_ILL_BIT] = trapStb[TRAP_ILL_BIT] & userMode;
    qualTrap[TRAP_FLG_BIT] = trapStb[TRAP_FLG_BIT] & flagBit;
  end

  assign anyTrap = |qualTrap;
  assign anyInt  = nmiPend | (intReq & intEn);

  // lowest-numbered qualified strobe wins
  always_comb begin
    trapCode = EXC_UND;
    for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
      if (qualTrap[i]) trapCode = trapCodeOf(i);
    end
  end

  always_comb begin
    sel          = '0;
    sel.code     = EXC_NONE;
    if (endStb) begin
      if (anyTrap) begin
        sel.load = 1'b1;
        sel.code = trapCode;
      end else if (interruptible && anyInt) begin
        sel.load     = 1'b1;
        sel.ackCycle = 1'b1;
        sel.nmiSel   = nmiPend;
        sel.code     = nmiPend ? EXC_NMI : EXC_INT;
      end else begin
        sel.done = 1'b1;
      end
    end else if (bndryStb) begin
      if (anyInt) begin
        sel.load     = 1'b1;
        sel.ackCycle = 1'b1;
        sel.nmiSel   = nmiPend;
        sel.code     = nmiPend ? EXC_NMI : EXC_INT;
      end else if (traceFlag) begin
        sel.load = 1'b1;
        sel.code = EXC_TRC;
      end
    end
  end
endmodule

// File: rtl/exc_dp.sv
module exc_dp
  import exc_pkg::*;
#(
  parameter int              VEC_W      = 8,
  parameter int              ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] INT_ADDR = 24'hFFFE00,
  parameter int              NMI_VECTOR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStb_t           sel,
  input  logic [VEC_W-1:0]  busVector,
  output logic              excValid,
  output logic [3:0]        excCode,
  output logic [VEC_W-1:0]  vecNum,
  output logic              retNext,
  output logic              iackReq,
  output logic [ADDR_W-1:0] iackAddr,
  output logic              instrDone
);
  logic [VEC_W-1:0]  vecD;
  logic [ADDR_W-1:0] addrD;

  always_comb begin
    case (sel.code)
      EXC_NONE: vecD = '0;
      EXC_NMI:  vecD = VEC_W'(NMI_VECTOR);
      EXC_INT:  vecD = busVector;
      default:  vecD = VEC_W'(sel.code);
    endcase
  end

  assign addrD = sel.ackCycle ? (sel.nmiSel ? NMI_ADDR : INT_ADDR) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid  <= 1'b0;
      excCode   <= '0;
      vecNum    <= '0;
      retNext   <= 1'b0;
      iackReq   <= 1'b0;
      iackAddr  <= '0;
      instrDone <= 1'b0;
    end else begin
      excValid  <= sel.load;
      excCode   <= sel.load ? sel.code : EXC_NONE;
      vecNum    <= sel.load ? vecD : '0;
      retNext   <= sel.load && (sel.code == EXC_TRC);
      iackReq   <= sel.load && sel.ackCycle;
      iackAddr  <= sel.load ? addrD : '0;
      instrDone <= sel.done;
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int                VEC_W       = 8,
  parameter int                ADDR_W      = 24,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] NMI_ADDR    = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] INT_ADDR    = 24'hFFFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPinN,
  input  logic              iackDone,
  input  logic              intReq,
  input  logic              intEn,
  input  logic              traceFlag,
  input  logic              bndryStb,
  input  logic              endStb,
  input  logic              interruptible,
  input  logic [6:0]        trapStb,
  input  logic              userMode,
  input  logic              flagBit,
  input  logic [VEC_W-1:0]  busVector,
  output logic              excValid,
  output logic [3:0]        excCode,
  output logic [VEC_W-1:0]  vecNum,
  output logic              retNext,
  output logic              iackReq,
  output logic [ADDR_W-1:0] iackAddr,
  output logic              instrDone
);
  logic    nmiPend;
  selStb_t sel;

  exc_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rstN(rstN), .pinN(nmiPinN), .ackDone(iackDone), .pending(nmiPend)
  );

  exc_ctrl u_ctrl (
    .bndryStb(bndryStb), .endStb(endStb), .interruptible(interruptible),
    .nmiPend(nmiPend), .intReq(intReq), .intEn(intEn), .traceFlag(traceFlag),
    .trapStb(trapStb), .userMode(userMode), .flagBit(flagBit), .sel(sel)
  );

  exc_dp #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR), .INT_ADDR(INT_ADDR), .NMI_VECTOR(1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sel(sel), .busVector(busVector),
    .excValid(excValid), .excCode(excCode), .vecNum(vecNum), .retNext(retNext),
    .iackReq(iackReq), .iackAddr(iackAddr), .instrDone(instrDone)
  );
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int                VEC_W    = 8,
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'hFFFF00
) (
  input logic              clk,
  input logic              rstN,
  input logic              bndryStb,
  input logic              endStb,
  input logic [6:0]        trapStb,
  input logic              userMode,
  input logic              flagBit,
  input logic              nmiPend,
  input logic              iackDone,
  input logic              excValid,
  input logic [3:0]        excCode,
  input logic [VEC_W-1:0]  vecNum,
  input logic              retNext,
  input logic              iackReq,
  input logic [ADDR_W-1:0] iackAddr,
  input logic              instrDone
);
  p_nmi_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd1) |-> (vecNum == VEC_W'(1) && iackReq && iackAddr == NMI_ADDR));

  p_trace_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd9) |-> (retNext && !iackReq));

  p_trap_current_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode != 4'd9) |-> !retNext);

  p_trap_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    endStb |-> $onehot0(trapStb));

  p_ill_user_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd4) |-> $past(userMode));

  p_flg_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 4'd7) |-> $past(flagBit));

  p_done_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |-> (!excValid && $past(endStb)));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(bndryStb || endStb));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |-> (vecNum == '0 && iackAddr == '0 && !iackReq && !retNext));

  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !iackDone) |=> nmiPend);
endmodule

bind exc_sequencer exc_sequencer_chk #(
  .VEC_W(VEC_W), .ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .bndryStb(bndryStb), .endStb(endStb), .trapStb(trapStb),
  .userMode(userMode), .flagBit(flagBit), .nmiPend(nmiPend), .iackDone(iackDone),
  .excValid(excValid), .excCode(excCode), .vecNum(vecNum), .retNext(retNext),
  .iackReq(iackReq), .iackAddr(iackAddr), .instrDone(instrDone)
);

// File: tb/exc_sequencer_test.sv
`timescale 1ns/1ps
module exc_sequencer_test;
  localparam int VEC_W = 8;
  localparam int ADDR_W = 24;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiPinN = 1'b1, iackDone = 1'b0, intReq = 1'b0, intEn = 1'b0, traceFlag = 1'b0;
  logic bndryStb = 1'b0, endStb = 1'b0, interruptible = 1'b0;
  logic [6:0] trapStb = '0;
  logic userMode = 1'b0, flagBit = 1'b0;
  logic [VEC_W-1:0] busVector = '0;
  logic excValid, retNext, iackReq, instrDone;
  logic [3:0] excCode;
  logic [VEC_W-1:0] vecNum;
  logic [ADDR_W-1:0] iackAddr;

  int errors = 0;
  int checks = 0;
  string curReq = "R11";

  always #2 clk = ~clk;

  exc_sequencer uut (
    .clk(clk), .rstN(rstN), .nmiPinN(nmiPinN), .iackDone(iackDone), .intReq(intReq),
    .intEn(intEn), .traceFlag(traceFlag), .bndryStb(bndryStb), .endStb(endStb),
    .interruptible(interruptible), .trapStb(trapStb), .userMode(userMode),
    .flagBit(flagBit), .busVector(busVector), .excValid(excValid), .excCode(excCode),
    .vecNum(vecNum), .retNext(retNext), .iackReq(iackReq), .iackAddr(iackAddr),
    .instrDone(instrDone)
  );

  // ---------------- reference model ----------------
  bit pinHist[$];
  bit mPend = 0;
  int mValid = 0, mCode = 0, mVec = 0, mRet = 0, mAck = 0, mAddr = 0, mDone = 0;
  int trapCodes[7] = '{3, 4, 5, 6, 7, 8, 10};

  initial for (int i = 0; i <= SYNC; i++) pinHist.push_back(1'b1);

  task automatic modelIntr();
    mValid = 1; mAck = 1;
    if (mPend) begin mCode = 1; mVec = 1; mAddr = 'hFFFF00; end
    else begin mCode = 2; mVec = busVector; mAddr = 'hFFFE00; end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinHist.delete();
      for (int i = 0; i <= SYNC; i++) pinHist.push_back(1'b1);
      mPend = 0; mValid = 0; mCode = 0; mVec = 0; mRet = 0; mAck = 0; mAddr = 0; mDone = 0;
    end else begin
      bit fall;
      bit intAny;
      int pick;
      fall = pinHist[SYNC] && !pinHist[SYNC-1];
      intAny = mPend || (intReq && intEn);
      mValid = 0; mCode = 0; mVec = 0; mRet = 0; mAck = 0; mAddr = 0; mDone = 0;
      pick = -1;
      for (int i = 6; i >= 0; i--) begin
        bit q;
        q = trapStb[i];
        if (i == 1) q = q && userMode;
        if (i == 4) q = q && flagBit;
        if (q) pick = i;
      end
      if (endStb) begin
        if (pick >= 0) begin mValid = 1; mCode = trapCodes[pick]; mVec = mCode; end
        else if (interruptible && intAny) modelIntr();
        else mDone = 1;
      end else if (bndryStb) begin
        if (intAny) modelIntr();
        else if (traceFlag) begin mValid = 1; mCode = 9; mVec = 9; mRet = 1; end
      end
      mPend = fall || (mPend && !iackDone);
      pinHist.push_front(nmiPinN);
      void'(pinHist.pop_back());
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (excValid !== 1'(mValid) || excCode !== 4'(mCode) || vecNum !== VEC_W'(mVec) ||
        retNext !== 1'(mRet) || iackReq !== 1'(mAck) || iackAddr !== ADDR_W'(mAddr) ||
        instrDone !== 1'(mDone)) begin
      errors++;
      $display("FAIL %s t=%0t actual v=%0b c=%0d vec=%0d r=%0b a=%0b ad=%h d=%0b expected v=%0d c=%0d vec=%0d r=%0d a=%0d ad=%h d=%0d",
               curReq, $time, excValid, excCode, vecNum, retNext, iackReq, iackAddr, instrDone,
               mValid, mCode, mVec, mRet, mAck, mAddr, mDone);
    end
  end

  // ---------------- spot checks against literal expectations ----------------
  task automatic expectOut(input string req, input int v, input int c, input int vec,
                           input int r, input int a, input int ad, input int d);
    checks++;
    if (excValid !== 1'(v) || excCode !== 4'(c) || vecNum !== VEC_W'(vec) || retNext !== 1'(r) ||
        iackReq !== 1'(a) || iackAddr !== ADDR_W'(ad) || instrDone !== 1'(d)) begin
      errors++;
      $display("FAIL %s actual v=%0b c=%0d vec=%0d r=%0b a=%0b ad=%h d=%0b expected v=%0d c=%0d vec=%0d r=%0d a=%0d ad=%h d=%0d",
               req, excValid, excCode, vecNum, retNext, iackReq, iackAddr, instrDone,
               v, c, vec, r, a, ad, d);
    end
  endtask

  task automatic doBoundary();
    @(negedge clk); bndryStb = 1'b1;
    @(negedge clk); bndryStb = 1'b0;
  endtask

  task automatic doEnd(input logic [6:0] t, input logic intr);
    @(negedge clk); trapStb = t; interruptible = intr; endStb = 1'b1;
    @(negedge clk); endStb = 1'b0; trapStb = '0; interruptible = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R11: reset state
    idle(3);
    expectOut("R11", 0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    idle(2);
    expectOut("R11", 0, 0, 0, 0, 0, 0, 0);

    // R8: clean completion
    curReq = "R8";
    doEnd(7'b0, 1'b1);
    expectOut("R8", 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    expectOut("R9", 0, 0, 0, 0, 0, 0, 0);

    // R4: trace at the boundary
    curReq = "R4";
    traceFlag = 1'b1;
    doBoundary();
    expectOut("R4", 1, 9, 9, 1, 0, 0, 0);
    idle(1);
    expectOut("R9", 0, 0, 0, 0, 0, 0, 0);

    // R3: maskable beats trace; enable masks it
    curReq = "R3";
    intReq = 1'b1; intEn = 1'b1; busVector = 8'h5A;
    doBoundary();
    expectOut("R3", 1, 2, 'h5A, 0, 1, 'hFFFE00, 0);
    intEn = 1'b0;
    doBoundary();
    expectOut("R3", 1, 9, 9, 1, 0, 0, 0);
    traceFlag = 1'b0;
    doBoundary();
    expectOut("R3", 0, 0, 0, 0, 0, 0, 0);

    // R5: each trap, with an interrupt also pending
    curReq = "R5";
    userMode = 1'b1; flagBit = 1'b1; intEn = 1'b1;
    for (int i = 0; i < 7; i++) begin
      doEnd(7'(1 << i), 1'b1);
      expectOut("R5", 1, trapCodes[i], trapCodes[i], 0, 0, 0, 0);
    end

    // R6: status-qualified traps ignored
    curReq = "R6";
    intReq = 1'b0;
    userMode = 1'b0;
    doEnd(7'b0000010, 1'b1);
    expectOut("R6", 0, 0, 0, 0, 0, 0, 1);
    userMode = 1'b1; flagBit = 1'b0;
    doEnd(7'b0010000, 1'b1);
    expectOut("R6", 0, 0, 0, 0, 0, 0, 1);

    // R7: interrupt at end of instruction only when interruptible
    curReq = "R7";
    intReq = 1'b1; busVector = 8'h33;
    doEnd(7'b0, 1'b1);
    expectOut("R7", 1, 2, 'h33, 0, 1, 'hFFFE00, 0);
    doEnd(7'b0, 1'b0);
    expectOut("R7", 0, 0, 0, 0, 0, 0, 1);

    // R1/R2/R3: non-maskable edge, fixed vector, ranks above maskable
    curReq = "R2";
    busVector = 8'h77;
    @(negedge clk); nmiPinN = 1'b0;
    idle(5);
    doBoundary();
    expectOut("R2", 1, 1, 1, 0, 1, 'hFFFF00, 0);
    @(negedge clk); iackDone = 1'b1;
    @(negedge clk); iackDone = 1'b0;
    curReq = "R1";
    intReq = 1'b0;
    idle(4);
    doBoundary();
    expectOut("R1", 0, 0, 0, 0, 0, 0, 0);

    // R10: two edges before acknowledge merge; one ack clears
    curReq = "R10";
    @(negedge clk); nmiPinN = 1'b1;
    idle(3);
    @(negedge clk); nmiPinN = 1'b0;
    idle(4);
    @(negedge clk); nmiPinN = 1'b1;
    idle(3);
    @(negedge clk); nmiPinN = 1'b0;
    idle(4);
    doBoundary();
    expectOut("R10", 1, 1, 1, 0, 1, 'hFFFF00, 0);
    doBoundary();
    expectOut("R10", 1, 1, 1, 0, 1, 'hFFFF00, 0);
    @(negedge clk); iackDone = 1'b1;
    @(negedge clk); iackDone = 1'b0;
    doBoundary();
    expectOut("R10", 0, 0, 0, 0, 0, 0, 0);

    idle(3);
    report();
  end
endmodule